// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral with three 16-bit registers on a simple memory-mapped bus. Software stores a value in an 8-bit up-counter and enables it. The counter then advances once per prescaler tick, and the prescaler divides the input clock by one of eight ratios. If software does not reload the counter before it passes 255, the block latches an overflow flag. When the reset enable bit is set, the block also drives a fixed-length reset pulse.

Every register write is guarded. The upper byte of the written word must carry the key that belongs to the target register, or the block drops the write with no effect. The overflow flag is sticky. It clears only when software first reads the reset-control register while the flag is set, and afterwards writes the clear word 0xA500 to that register. Reloading the counter acts as the keep-alive ping. Clearing the enable bit stops counting.

Top module: `guard_wdt`

## Requirements
- R1: After reset the three registers read 0x0000 and the reset output is low.
- R2: Byte offset 0 is the control register. A write with upper byte 0xA5 stores bit 6 as watchdog mode, bit 5 as timer enable and bits 2:0 as the clock code. A read returns those bits in the same positions and zeros in all other bits.
- R3: Byte offset 2 is the counter. A write with upper byte 0x5A loads the low byte into the counter, and a read returns the counter in bits 7:0.
- R4: Byte offset 4 is the reset-control register. A write with upper byte 0x5A stores bit 6 as the reset enable. A read returns the overflow flag in bit 7 and the reset enable in bit 6.
- R5: A write whose upper byte is not the key of its register changes nothing.
- R6: Clock codes 0 to 7 divide the clock by 1, 64, 128, 256, 512, 1024, 4096 and 16384. The first increment comes N clocks after the edge that enables the timer, where N is the divide ratio.
- R7: While the timer is disabled the counter holds its value. Disabling the timer restarts the prescaler, so after re-enabling, a full N clocks pass before the next increment.
- R8: In watchdog mode, an increment from 255 wraps the counter to 0 and sets the sticky overflow flag.
- R9: With watchdog mode clear, the counter wraps without setting the flag and without a pulse.
- R10: An overflow in watchdog mode with the reset enable set drives the reset output high for exactly 16 clocks, starting with the overflowing edge. The flag stays set after the pulse ends.
- R11: Writing 0xA500 to offset 4 clears the flag only if an earlier read of offset 4 returned the flag set. Without such a read the write is ignored.
- R12: A keyed counter write in the same cycle as a tick loads the written value, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Byte offset of the accessed register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; a read of offset 4 can arm the flag clear |
| busWrData | input | 16 | Write data including the key byte |
| busRdData | output | 16 | Read data of the addressed register (combinational) |
| wdtRstOut | output | 1 | Watchdog reset pulse |

## Verification
On every cycle the assertions check four things. A write with a wrong key to the control register leaves it unchanged. A disabled timer does not count unless software loads it. The flag only falls on the clear word and never rises outside watchdog mode. The reset pulse never starts without the flag. Only the bench scenarios can show the timing behaviours: the exact divide ratios, including the slowest one, the 16-clock pulse width, and the read-before-clear ordering. They also show the load-over-tick priority and the register read-back layout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 16;
  localparam int KEY_W = 8;
  localparam int CNT_W = 8;
  localparam int CKS_W = 3;
  localparam int ADDR_W = 3;
  localparam int NUM_CODES = 1 << CKS_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RST  = 3'd4;

  localparam logic [KEY_W-1:0] KEY_CTRL = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_CNT  = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_RST  = 8'h5A;
  localparam logic [REG_W-1:0] CLEAR_WORD = 16'hA500;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic             loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic             clearOvf;
  } wdtStrobe_t;

  // log2 of the divide ratio for each clock code
  function automatic int tapShift(input int code);
    case (code)
      0: return 0;
      1: return 6;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 12;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfFlag,
  output logic [REG_W-1:0]  busRdData,
  output logic              modeSel,
  output logic              timerEn,
  output logic [CKS_W-1:0]  clkSel,
  output logic              rstEn,
  output wdtStrobe_t        strb
);
  logic [KEY_W-1:0] keyByte;
  logic             ctrlHit, cntHit, rstHit, clearHit;
  logic             armed;

  assign keyByte  = busWrData[REG_W-1 -: KEY_W];
  assign ctrlHit  = busWrEn && (busAddr == OFS_CTRL) && (keyByte == KEY_CTRL);
  assign cntHit   = busWrEn && (busAddr == OFS_CNT)  && (keyByte == KEY_CNT);
  assign rstHit   = busWrEn && (busAddr == OFS_RST)  && (keyByte == KEY_RST);
  assign clearHit = busWrEn && (busAddr == OFS_RST)  && (busWrData == CLEAR_WORD) && armed;

  always_comb begin
    strb.loadCnt  = cntHit;
    strb.loadVal  = busWrData[CNT_W-1:0];
    strb.clearOvf = clearHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= 1'b0;
      timerEn <= 1'b0;
      clkSel  <= '0;
    end else if (ctrlHit) begin
      modeSel <= busWrData[6];
      timerEn <= busWrData[5];
      clkSel  <= busWrData[CKS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rstEn <= 1'b0;
    else if (rstHit) rstEn <= busWrData[6];
  end

  // A read that observes the flag arms the clear word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          armed <= 1'b0;
    else if (clearHit)                                  armed <= 1'b0;
    else if (busRdEn && (busAddr == OFS_RST) && ovfFlag) armed <= 1'b1;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CTRL: busRdData[7:0] = {1'b0, modeSel, timerEn, {(5-CKS_W){1'b0}}, clkSel};
      OFS_CNT:  busRdData[CNT_W-1:0] = count;
      OFS_RST:  busRdData[7:0] = {ovfFlag, rstEn, 6'b0};
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DIV_W     = 14,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             timerEn,
  input  logic [CKS_W-1:0] clkSel,
  input  logic             rstEn,
  input  wdtStrobe_t       strb,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             wdtRstOut
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] maskTab [NUM_CODES];
  logic [DIV_W-1:0] tapMask;
  logic             tick, wrapEvt, trip;
  logic [PW-1:0]    pulseCnt;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_mask
    localparam int SH = tapShift(g);
    assign maskTab[g] = DIV_W'((64'(1) << SH) - 64'(1));
  end

  assign tapMask = maskTab[clkSel];
  assign tick    = timerEn && ((divCnt & tapMask) == tapMask);
  assign wrapEvt = tick && !strb.loadCnt && (count == {CNT_W{1'b1}});
  assign trip    = wrapEvt && modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (!timerEn) divCnt <= '0;
    else               divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.loadCnt) count <= strb.loadVal;
    else if (tick)         count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (trip)          ovfFlag <= 1'b1;
    else if (strb.clearOvf) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (trip && rstEn)  pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - PW'(1);
  end

  assign wdtRstOut = (pulseCnt != '0);
endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import wdt_pkg::*;
#(
  parameter int DIV_W     = 14,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic              wdtRstOut
);
  logic             modeSel, timerEn, rstEn, ovfFlag;
  logic [CKS_W-1:0] clkSel;
  logic [CNT_W-1:0] count;
  wdtStrobe_t       strb;

  wdt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .count(count),
    .ovfFlag(ovfFlag), .busRdData(busRdData), .modeSel(modeSel),
    .timerEn(timerEn), .clkSel(clkSel), .rstEn(rstEn), .strb(strb)
  );

  wdt_datapath #(.DIV_W(DIV_W), .PULSE_LEN(PULSE_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .timerEn(timerEn),
    .clkSel(clkSel), .rstEn(rstEn), .strb(strb), .count(count),
    .ovfFlag(ovfFlag), .wdtRstOut(wdtRstOut)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [REG_W-1:0]  busWrData,
  input logic              modeSel,
  input logic              timerEn,
  input logic [CKS_W-1:0]  clkSel,
  input logic              loadCnt,
  input logic [CNT_W-1:0]  count,
  input logic              ovfFlag,
  input logic              wdtRstOut
);
  AST_BAD_KEY_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_CTRL && busWrData[15:8] != KEY_CTRL)
      |=> ($stable(modeSel) && $stable(timerEn) && $stable(clkSel))); // R5

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !loadCnt) |=> $stable(count)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWrEn && busAddr == OFS_RST && busWrData == CLEAR_WORD))
      |=> ovfFlag); // R11

  AST_NO_FLAG_INTERVAL: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && !ovfFlag) |=> !ovfFlag); // R9

  AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtRstOut) |-> ovfFlag); // R10
endmodule

bind guard_wdt wdt_checker i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .modeSel(modeSel), .timerEn(timerEn),
  .clkSel(clkSel), .loadCnt(strb.loadCnt), .count(count),
  .ovfFlag(ovfFlag), .wdtRstOut(wdtRstOut)
);

// File: tb/test_guard_wdt.sv
module test_guard_wdt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        wdtRstOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  guard_wdt i_guard_wdt (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .wdtRstOut(wdtRstOut)
  );

  // {isWrite, addr, data, expected read}; register tests with the timer stopped
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'hA547, 16'h0000},  // R2 mode, code 7, disabled
    {1'b0, 3'd0, 16'h0000, 16'h0047},
    {1'b1, 3'd0, 16'h5A00, 16'h0000},  // R5 wrong key
    {1'b0, 3'd0, 16'h0000, 16'h0047},
    {1'b1, 3'd2, 16'h5A3C, 16'h0000},  // R3 load
    {1'b0, 3'd2, 16'h0000, 16'h003C},
    {1'b1, 3'd2, 16'hA5FF, 16'h0000},  // R5 wrong key
    {1'b0, 3'd2, 16'h0000, 16'h003C},
    {1'b1, 3'd4, 16'h5A40, 16'h0000},  // R4 reset enable
    {1'b0, 3'd4, 16'h0000, 16'h0040},
    {1'b1, 3'd4, 16'h1200, 16'h0000},  // R5 wrong key
    {1'b0, 3'd4, 16'h0000, 16'h0040},
    {1'b1, 3'd0, 16'hA598, 16'h0000},  // R2 undefined bits dropped
    {1'b0, 3'd0, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    bit seen;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    peek(3'd0, v); check("R1 ctrl", v, 16'h0000);
    peek(3'd2, v); check("R1 cnt", v, 16'h0000);
    peek(3'd4, v); check("R1 rstctl", v, 16'h0000);
    check("R1 rstOut", {15'b0, wdtRstOut}, 16'h0000);

    // Table walk: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][35]) wr(VEC[k][34:32], VEC[k][31:16]);
      else begin
        rd(VEC[k][34:32], v);
        check($sformatf("R2/R3/R4/R5 step %0d", k), v, VEC[k][15:0]);
      end
    end

    // R8 R10: overflow with reset enable (rstEn already 1)
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    @(negedge clk);
    peek(3'd4, v); check("R8 flag set", v, 16'h00C0);
    peek(3'd2, v); check("R8 wrap to 0", v, 16'h0000);
    n = 0;
    while (wdtRstOut && n < 40) begin n++; @(negedge clk); end
    check("R10 pulse length", 16'(n), 16'd16);
    wr(3'd0, 16'hA540);
    peek(3'd4, v); check("R10 flag survives pulse", v, 16'h00C0);

    // R11: clear without prior read is ignored, then proper sequence
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R11 unarmed clear ignored", v, 16'h00C0);
    rd(3'd4, v); check("R11 arming read", v, 16'h00C0);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R11 armed clear", v, 16'h0040);

    // R9: interval mode wraps silently; also code 0 rate (R6)
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA520);
    seen = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (wdtRstOut) seen = 1'b1; end
    peek(3'd2, v); check("R6 code0 one per clock", v, 16'h0002);
    peek(3'd4, v); check("R9 no flag", v, 16'h0040);
    check("R9 no pulse", {15'b0, seen}, 16'h0000);

    // R12: load during a tick wins
    wr(3'd2, 16'h5A10);
    peek(3'd2, v); check("R12 load over tick", v, 16'h0010);
    @(negedge clk);
    peek(3'd2, v); check("R12 counts after load", v, 16'h0011);

    // R7: disabled counter holds
    wr(3'd0, 16'hA500);
    peek(3'd2, v);
    idle(5);
    begin
      logic [15:0] w;
      peek(3'd2, w); check("R7 hold while disabled", w, v);
    end

    // R6: code 1 (64)
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA521);
    idle(63);
    peek(3'd2, v); check("R6 code1 before tick", v, 16'h0000);
    idle(1);
    peek(3'd2, v); check("R6 code1 tick at 64", v, 16'h0001);

    // R7: disabling restarts the prescaler
    idle(40);
    wr(3'd0, 16'hA501);
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA521);
    idle(63);
    peek(3'd2, v); check("R7 prescaler restarted", v, 16'h0000);
    idle(1);
    peek(3'd2, v); check("R7 full period after restart", v, 16'h0001);

    // R6: code 7 (16384)
    wr(3'd0, 16'hA500);
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA527);
    idle(16383);
    peek(3'd2, v); check("R6 code7 before tick", v, 16'h0000);
    idle(1);
    peek(3'd2, v); check("R6 code7 tick at 16384", v, 16'h0001);

    // R10: overflow with reset enable clear gives flag but no pulse
    wr(3'd0, 16'hA500);
    wr(3'd4, 16'h5A00);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (wdtRstOut) seen = 1'b1; end
    wr(3'd0, 16'hA540);
    peek(3'd4, v); check("R8 flag without reset enable", v, 16'h0080);
    check("R10 no pulse when disabled", {15'b0, seen}, 16'h0000);

    done = 1'b1;
    finishRun();
  end
endmodule